// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block collects seven event sources of a system timer (six channel events and one counter overflow event) into one interrupt request. Each source owns a raw status bit that records that the event happened, an enable (mask) bit, and a masked status bit that is the logical AND of the two. The OR of the masked bits, taken through a register, drives the interrupt line.

Software reaches the block through write-one strobes. One port sets raw status bits, one clears them, and a second pair sets and clears enable bits. The whole enable word can also be loaded in one write. Alongside software, each timer channel supplies a clear pulse that the bus logic raises when that channel's capture/compare value is read, so that a read also acknowledges the event. Hardware events always take precedence over clears that arrive in the same cycle, so no event is lost.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Bit k, for k from 0 to 5, of the status, enable and masked words belongs to timer channel k, and bit 6 belongs to the counter overflow. Every output bit above bit 6 reads 0.
- R2: A masked status bit is 1 exactly when both its raw status bit and its enable bit are 1.
- R3: A 1 on bit k of `sw_set_i` makes raw bit k read 1 from the next clock edge on. A 0 leaves the bit unchanged.
- R4: A 1 on bit k of `sw_clr_i` makes raw bit k read 0 after the next edge, unless that bit is also being set in the same cycle.
- R5: A 1 on bit k of `hw_evt_i` makes raw bit k read 1 after the next edge.
- R6: When a hardware event or a software set reaches the same bit as a software clear or a read-clear in the same cycle, the bit ends up 1.
- R7: A 1 on bit k of `rd_clr_i` clears raw bit k of channel k after the next edge. The overflow bit (bit 6) has no read-clear and is not affected.
- R8: A 1 on `msk_set_i` bit k sets enable bit k, and a 1 on `msk_clr_i` bit k clears it. A 0 on either has no effect. If both hit the same bit in one cycle, the set wins.
- R9: With `msk_wr_en_i` high, the enable word becomes `msk_wr_data_i` after the edge. This replaces every enable bit and overrides the set and clear strobes of that cycle.
- R10: After reset, the raw status, enable, masked status and interrupt output are all 0.
- R11: `irq_o` equals the OR of the masked status bits as they were one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt_i | input | NUM_SRC (7) | Per-source hardware event pulses |
| sw_set_i | input | NUM_SRC (7) | Write-one-to-set strobes for raw status |
| sw_clr_i | input | NUM_SRC (7) | Write-one-to-clear strobes for raw status |
| rd_clr_i | input | NUM_CHAN (6) | Per-channel clear pulses from value-register reads |
| msk_set_i | input | NUM_SRC (7) | Write-one-to-set strobes for enable bits |
| msk_clr_i | input | NUM_SRC (7) | Write-one-to-clear strobes for enable bits |
| msk_wr_en_i | input | 1 | Whole-word enable write strobe |
| msk_wr_data_i | input | NUM_SRC (7) | Data for whole-word enable write |
| raw_o | output | REG_W (32) | Raw status word, zero above the sources |
| mask_o | output | REG_W (32) | Enable word, zero above the sources |
| masked_o | output | REG_W (32) | Masked status word, zero above the sources |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a collision in a single cycle: an event or a set on a bit at the same edge as a software clear and a read-clear on that bit. A second collision is a whole-word enable load in the same cycle as the enable strobes. The stimulus table has rows that apply these inputs together in one cycle, then reads the word one edge later to confirm that the set or the word load won. The interrupt latency is checked by sampling `irq_o` both at the first edge after the masked bit changes and at the edge after that.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // Selects how the interrupt line is produced from the masked status
   typedef enum logic [0:0] {
      IRQ_FLOPPED = 1'b0,
      IRQ_DIRECT  = 1'b1
   } irq_out_e;

   // Zero-extend a narrow source vector into a register-width word
   function automatic logic [63:0] widen(input logic [63:0] v, input int unsigned n);
      logic [63:0] r;
      r = '0;
      for (int unsigned i = 0; i < n; i++) r[i] = v[i];
      return r;
   endfunction

endpackage

// File: rtl/evt_stat_cell.sv
// One raw status bit. Set sources take precedence over clear sources.
module evt_stat_cell #(
   parameter bit HAS_RD_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_evt,
   input  logic sw_set,
   input  logic sw_clr,
   input  logic rd_clr,
   output logic stat_q
);
   logic clr_any;

   generate
      if (HAS_RD_CLR) begin : g_rdclr
         assign clr_any = sw_clr | rd_clr;
      end else begin : g_nordclr
         logic unused_rd;
         assign unused_rd = rd_clr;
         assign clr_any   = sw_clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                stat_q <= 1'b0;
      else if (hw_evt | sw_set)  stat_q <= 1'b1;
      else if (clr_any)          stat_q <= 1'b0;
   end
endmodule

// File: rtl/evt_mask_reg.sv
// Enable register: whole-word load, then set strobes, then clear strobes.
module evt_mask_reg #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] mask_q
);
   logic [WIDTH-1:0] mask_d;

   always_comb begin
      if (wr_en_i) mask_d = wr_data_i;
      else         mask_d = (mask_q & ~clr_i) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/evt_irq_reduce.sv
// OR-reduction of masked status into the interrupt line; variant by parameter.
module evt_irq_reduce
   import evt_irq_pkg::*;
#(
   parameter int unsigned WIDTH    = 7,
   parameter irq_out_e    IRQ_MODE = IRQ_FLOPPED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pend_i,
   output logic             irq_o
);
   logic any_pend;
   assign any_pend = |pend_i;

   generate
      if (IRQ_MODE == IRQ_FLOPPED) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_pend;
         end
         assign irq_o = irq_q;
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o      = any_pend;
      end
   endgenerate
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 6,
   parameter int unsigned NUM_SRC  = 7,
   parameter int unsigned REG_W    = 32,
   parameter irq_out_e    IRQ_MODE = IRQ_FLOPPED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  hw_evt_i,
   input  logic [NUM_SRC-1:0]  sw_set_i,
   input  logic [NUM_SRC-1:0]  sw_clr_i,
   input  logic [NUM_CHAN-1:0] rd_clr_i,
   input  logic [NUM_SRC-1:0]  msk_set_i,
   input  logic [NUM_SRC-1:0]  msk_clr_i,
   input  logic                msk_wr_en_i,
   input  logic [NUM_SRC-1:0]  msk_wr_data_i,
   output logic [REG_W-1:0]    raw_o,
   output logic [REG_W-1:0]    mask_o,
   output logic [REG_W-1:0]    masked_o,
   output logic                irq_o
);
   localparam int unsigned PAD_W = (REG_W > NUM_SRC) ? REG_W - NUM_SRC : 1;

   generate
      if (NUM_SRC != NUM_CHAN + 1) begin : g_bad_src
         $error("evt_irq_ctrl: NUM_SRC must be NUM_CHAN + 1");
      end
      if (REG_W < NUM_SRC || REG_W > 64) begin : g_bad_w
         $error("evt_irq_ctrl: REG_W must lie between NUM_SRC and 64");
      end
   endgenerate

   logic [NUM_SRC-1:0] raw_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pend;

   // One status cell per source; only channel sources have a read-clear
   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         if (k < NUM_CHAN) begin : g_chan
            evt_stat_cell #(.HAS_RD_CLR(1'b1)) u_cell (
               .clk    (clk),
               .rst_n  (rst_n),
               .hw_evt (hw_evt_i[k]),
               .sw_set (sw_set_i[k]),
               .sw_clr (sw_clr_i[k]),
               .rd_clr (rd_clr_i[k]),
               .stat_q (raw_q[k])
            );
         end else begin : g_ovf
            evt_stat_cell #(.HAS_RD_CLR(1'b0)) u_cell (
               .clk    (clk),
               .rst_n  (rst_n),
               .hw_evt (hw_evt_i[k]),
               .sw_set (sw_set_i[k]),
               .sw_clr (sw_clr_i[k]),
               .rd_clr (1'b0),
               .stat_q (raw_q[k])
            );
         end
      end
   endgenerate

   evt_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (msk_set_i),
      .clr_i     (msk_clr_i),
      .wr_en_i   (msk_wr_en_i),
      .wr_data_i (msk_wr_data_i),
      .mask_q    (mask_q)
   );

   assign pend = raw_q & mask_q;

   evt_irq_reduce #(.WIDTH(NUM_SRC), .IRQ_MODE(IRQ_MODE)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .irq_o  (irq_o)
   );

   // Register-width views, zero above the implemented sources
   generate
      if (REG_W > NUM_SRC) begin : g_pad
         assign raw_o    = {{PAD_W{1'b0}}, raw_q};
         assign mask_o   = {{PAD_W{1'b0}}, mask_q};
         assign masked_o = {{PAD_W{1'b0}}, pend};
      end else begin : g_nopad
         assign raw_o    = raw_q;
         assign mask_o   = mask_q;
         assign masked_o = pend;
      end
   endgenerate
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 6,
   parameter int unsigned NUM_SRC  = 7,
   parameter int unsigned REG_W    = 32,
   parameter irq_out_e    IRQ_MODE = IRQ_FLOPPED
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SRC-1:0]  hw_evt_i,
   input logic [NUM_SRC-1:0]  sw_set_i,
   input logic [NUM_SRC-1:0]  sw_clr_i,
   input logic [NUM_CHAN-1:0] rd_clr_i,
   input logic [NUM_SRC-1:0]  msk_set_i,
   input logic [NUM_SRC-1:0]  msk_clr_i,
   input logic                msk_wr_en_i,
   input logic [NUM_SRC-1:0]  msk_wr_data_i,
   input logic [REG_W-1:0]    raw_o,
   input logic [REG_W-1:0]    mask_o,
   input logic [REG_W-1:0]    masked_o,
   input logic                irq_o
);
   logic [NUM_SRC-1:0] set_any;
   logic [NUM_SRC-1:0] rd_ext;
   logic [NUM_SRC-1:0] raw_s;
   logic [NUM_SRC-1:0] mask_s;

   assign set_any = hw_evt_i | sw_set_i;
   assign rd_ext  = {1'b0, rd_clr_i};
   assign raw_s   = raw_o[NUM_SRC-1:0];
   assign mask_s  = mask_o[NUM_SRC-1:0];

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_any) |=> ((raw_s & $past(set_any)) == $past(set_any)));

   // R4
   sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sw_clr_i & ~set_any)) |=> ((raw_s & $past(sw_clr_i & ~set_any)) == '0));

   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rd_ext & ~set_any)) |=> ((raw_s & $past(rd_ext & ~set_any)) == '0));

   // R3
   no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any == '0) |=> ((raw_s & ~$past(raw_s)) == '0));

   // R9
   mask_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msk_wr_en_i |=> (mask_s == $past(msk_wr_data_i)));

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!msk_wr_en_i && (|msk_set_i)) |=> ((mask_s & $past(msk_set_i)) == $past(msk_set_i)));

   // R2
   masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((masked_o & ~(raw_o & mask_o)) == '0) && (((raw_o & mask_o) & ~masked_o) == '0));

   generate
      if (IRQ_MODE == IRQ_FLOPPED) begin : g_irq_chk
         // R11
         irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|masked_o) |=> irq_o);
         // R11
         irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (masked_o == '0) |=> !irq_o);
      end
   endgenerate
endmodule

bind evt_irq_ctrl evt_irq_chk #(
   .NUM_CHAN (NUM_CHAN),
   .NUM_SRC  (NUM_SRC),
   .REG_W    (REG_W),
   .IRQ_MODE (IRQ_MODE)
) u_evt_irq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hw_evt_i      (hw_evt_i),
   .sw_set_i      (sw_set_i),
   .sw_clr_i      (sw_clr_i),
   .rd_clr_i      (rd_clr_i),
   .msk_set_i     (msk_set_i),
   .msk_clr_i     (msk_clr_i),
   .msk_wr_en_i   (msk_wr_en_i),
   .msk_wr_data_i (msk_wr_data_i),
   .raw_o         (raw_o),
   .mask_o        (mask_o),
   .masked_o      (masked_o),
   .irq_o         (irq_o)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  hw_evt, sw_set, sw_clr, msk_set, msk_clr, msk_data;
   logic [5:0]  rd_clr;
   logic        msk_we;
   logic [31:0] raw_o, mask_o, masked_o;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   evt_irq_ctrl i_evt_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_evt_i(hw_evt), .sw_set_i(sw_set),
      .sw_clr_i(sw_clr), .rd_clr_i(rd_clr), .msk_set_i(msk_set),
      .msk_clr_i(msk_clr), .msk_wr_en_i(msk_we), .msk_wr_data_i(msk_data),
      .raw_o(raw_o), .mask_o(mask_o), .masked_o(masked_o), .irq_o(irq_o)
   );

   // Row: hw, set, clr, rd, mset, mclr, we, mdata, exp_raw, exp_mask
   typedef struct packed {
      logic [6:0] hw;
      logic [6:0] set;
      logic [6:0] clr;
      logic [5:0] rd;
      logic [6:0] mset;
      logic [6:0] mclr;
      logic       we;
      logic [6:0] mdata;
      logic [6:0] e_raw;
      logic [6:0] e_mask;
   } row_t;

   localparam int NROW = 13;
   localparam logic [66:0] ROWS [NROW] = '{
      {7'h00, 7'h05, 7'h00, 6'h00, 7'h00, 7'h00, 1'b0, 7'h00, 7'h05, 7'h00}, // R3 set
      {7'h00, 7'h00, 7'h00, 6'h00, 7'h0F, 7'h00, 1'b0, 7'h00, 7'h05, 7'h0F}, // R8 mask set
      {7'h00, 7'h00, 7'h01, 6'h00, 7'h00, 7'h00, 1'b0, 7'h00, 7'h04, 7'h0F}, // R4 clear
      {7'h40, 7'h00, 7'h00, 6'h00, 7'h00, 7'h00, 1'b0, 7'h00, 7'h44, 7'h0F}, // R5 overflow event
      {7'h02, 7'h00, 7'h02, 6'h02, 7'h00, 7'h00, 1'b0, 7'h00, 7'h46, 7'h0F}, // R6 event beats clears
      {7'h00, 7'h00, 7'h00, 6'h04, 7'h00, 7'h00, 1'b0, 7'h00, 7'h42, 7'h0F}, // R7 read clear ch2
      {7'h00, 7'h00, 7'h00, 6'h3F, 7'h00, 7'h00, 1'b0, 7'h00, 7'h40, 7'h0F}, // R7 overflow kept
      {7'h00, 7'h00, 7'h00, 6'h00, 7'h00, 7'h03, 1'b0, 7'h00, 7'h40, 7'h0C}, // R8 mask clear
      {7'h00, 7'h00, 7'h00, 6'h00, 7'h01, 7'h00, 1'b1, 7'h50, 7'h40, 7'h50}, // R9 word overrides
      {7'h00, 7'h00, 7'h00, 6'h00, 7'h20, 7'h20, 1'b0, 7'h00, 7'h40, 7'h70}, // R8 set beats clear
      {7'h00, 7'h01, 7'h01, 6'h00, 7'h00, 7'h00, 1'b0, 7'h00, 7'h41, 7'h70}, // R6 set beats clear
      {7'h00, 7'h00, 7'h7F, 6'h00, 7'h00, 7'h00, 1'b0, 7'h00, 7'h00, 7'h70}, // R4 clear all
      {7'h00, 7'h00, 7'h00, 6'h00, 7'h00, 7'h00, 1'b1, 7'h00, 7'h00, 7'h00}  // R9 word to zero
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      hw_evt = '0; sw_set = '0; sw_clr = '0; rd_clr = '0;
      msk_set = '0; msk_clr = '0; msk_we = 1'b0; msk_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      check("R10 raw", raw_o, 32'h0);
      check("R10 mask", mask_o, 32'h0);
      check("R10 masked", masked_o, 32'h0);
      check("R10 irq", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROW; i++) begin
         row_t r;
         r = row_t'(ROWS[i]);
         hw_evt = r.hw; sw_set = r.set; sw_clr = r.clr; rd_clr = r.rd;
         msk_set = r.mset; msk_clr = r.mclr; msk_we = r.we; msk_data = r.mdata;
         @(negedge clk);
         idle();
         check($sformatf("R3-row%0d raw", i), raw_o, {25'h0, r.e_raw});
         check($sformatf("R8-row%0d mask", i), mask_o, {25'h0, r.e_mask});
         // R2 masked word follows raw AND enable
         check($sformatf("R2-row%0d masked", i), masked_o, {25'h0, r.e_raw & r.e_mask});
      end

      // R2: pending but disabled source keeps irq low
      sw_set = 7'h08;
      @(negedge clk); idle();
      @(negedge clk);
      check("R2 irq disabled", {31'h0, irq_o}, 32'h0);

      // R11: enable the source; masked rises at edge, irq one edge later
      msk_set = 7'h08;
      @(negedge clk); idle();
      check("R11 masked up", masked_o, 32'h08);
      check("R11 irq still low", {31'h0, irq_o}, 32'h0);
      @(negedge clk);
      check("R11 irq high", {31'h0, irq_o}, 32'h1);

      // R7: read clear of channel 3 drops masked, irq follows one edge later
      rd_clr = 6'h08;
      @(negedge clk); idle();
      check("R7 raw cleared", raw_o, 32'h0);
      check("R11 irq lags", {31'h0, irq_o}, 32'h1);
      @(negedge clk);
      check("R11 irq low", {31'h0, irq_o}, 32'h0);

      // R1: all sources set, upper bits stay zero
      sw_set = 7'h7F; msk_we = 1'b1; msk_data = 7'h7F;
      @(negedge clk); idle();
      check("R1 raw width", raw_o, 32'h7F);
      check("R1 mask width", mask_o, 32'h7F);
      check("R1 masked width", masked_o, 32'h7F);

      // R8: zero strobes leave enables unchanged
      msk_set = 7'h00; msk_clr = 7'h00;
      @(negedge clk); idle();
      check("R8 zero writes", mask_o, 32'h7F);

      // R10: reset mid-run returns everything to zero
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 raw after reset", raw_o, 32'h0);
      check("R10 mask after reset", mask_o, 32'h0);
      check("R10 irq after reset", {31'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule